// File: doc/BRIEF.md
# Fuse Program Permission Checker

This block sits between a fuse programming request and a one-time-programmable fuse array, and decides whether the request may burn the addressed bit. A request carries a 17-bit bit address: page in bits 16:13, row in bits 12:5 and column in bits 4:0. The decision draws on four inputs. The first is a global program-enable configuration bit. The second is a sticky software lock that protects a band of page-0 rows. The third is a fixed table that names, for each protected row, a guard fuse in page 0 row 43. The fourth is the present value of that guard fuse, fetched through a single-bit lookup port. A permitted request produces a one-cycle set-bit command to the array. Every request ends by raising a done flag. A denial, or a failure reported by the array, also raises an error flag.

A state machine drives the sequence. S_IDLE accepts a request, latches the address and moves to S_CLASSIFY. S_CLASSIFY goes to S_FINISH on an outright denial, to S_PROGRAM on an outright permit, and to S_LOOKUP when a guard fuse must be read. S_LOOKUP issues the guard read and always moves to S_CHECK. S_CHECK moves to S_FINISH when the guard fuse is 1 and to S_PROGRAM when it is 0. S_PROGRAM issues the set command and moves to S_FINISH. S_FINISH posts the flags and returns to S_IDLE. The busy output is high in every state except S_IDLE.

Top module: `fuse_prog_guard`

## Requirements
- R1: The request address is decoded as page = bits 16:13, row = bits 12:5, column = bits 4:0. The set command carries the request address unchanged. A guard lookup addresses page 0, row 43, with the guard column in bits 4:0.
- R2: While cfg_prog_en is 0, every request is denied: there is no set command, no lookup, and the error flag is raised.
- R3: On page 0, while the sticky lock is 1, rows 44 to 51 are denied without a lookup.
- R4: On page 0, each protected row is guarded by one column of row 43: row 4 by column 31, row 37 by column 28, rows 8-11 by column 27, rows 12-19 by column 11, rows 20-27 by column 13, rows 28-35 by column 15, rows 64-71 by column 6, rows 72-79 by column 7 and rows 80-87 by column 8. Such a request is denied when its guard fuse reads 1 and permitted when it reads 0. Other page-0 rows are permitted without a lookup.
- R5: On page 2, addresses from row 129 column 0 through row 255 column 27 inclusive are guarded by row 43 column 16. Every other page-2 address, and every address on the remaining pages, is permitted without a lookup.
- R6: A write to the sticky lock uses only bit 0 of lock_wdata and ignores bits 31:1. Once the lock is 1, a write of 0 does not clear it; only reset does.
- R7: Every accepted request sets done_flag. A denied request, or a permitted one where set_fail is high during the set command, also sets err_flag. flag_clr bit 0 clears done_flag and bit 1 clears err_flag.
- R8: The block never clears err_flag on its own: a later successful request leaves it at 1.
- R9: The flags post a fixed number of clock edges after the edge that accepts the request. The counts are 2 for an outright denial, 3 for an outright permit, 4 for a denial by guard fuse and 5 for a permit after a lookup. busy is low when the flags post.
- R10: A request presented while busy is high is ignored.
- R11: The set command is a single-cycle pulse that is issued only for a permitted request, never in the same cycle as a lookup. After a lookup it is issued only if the guard fuse read 0. The guard value is due on lk_bit in the cycle after lk_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prog_en | input | 1 | Global program enable |
| lock_wr | input | 1 | Write strobe for the sticky lock |
| lock_wdata | input | 32 | Write data for the sticky lock; only bit 0 is used |
| lock_q | output | 1 | Sticky lock value |
| req_valid | input | 1 | Program request strobe |
| req_addr | input | 17 | Program request bit address |
| busy | output | 1 | A request is in progress |
| lk_req | output | 1 | Guard fuse lookup request |
| lk_addr | output | 17 | Guard fuse bit address |
| lk_bit | input | 1 | Guard fuse value, due the cycle after lk_req |
| set_valid | output | 1 | Set-bit command to the fuse array |
| set_addr | output | 17 | Bit address of the set command |
| set_fail | input | 1 | Array reports the set command failed |
| flag_clr | input | 2 | Write-1-to-clear: bit 0 done, bit 1 error |
| done_flag | output | 1 | Program-done flag |
| err_flag | output | 1 | Program-error flag |

## Verification
Counted from the edge that accepts a request, the flags post after 2, 3, 4 or 5 edges, depending on whether the request is denied outright, permitted outright, denied by its guard fuse or permitted after a lookup. Each request's check reads done_flag at the falling edge one cycle before that count, where it must still hold its prior value, and again at the falling edge right after the count, where it must be set and busy must be low. The set and lookup pulses are counted at falling edges, and their addresses are captured there. The guard value is served one cycle after lk_req, which matches the one-cycle lookup cost.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    localparam int ADDR_W = 17;
    localparam int PAGE_W = 4;
    localparam int ROW_W  = 8;
    localparam int COL_W  = 5;
    localparam int OFS_W  = ROW_W + COL_W;

    typedef enum logic [1:0] {
        V_ALLOW  = 2'd0,
        V_DENY   = 2'd1,
        V_LOOKUP = 2'd2
    } verdict_t;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_CLASSIFY = 3'd1,
        S_LOOKUP   = 3'd2,
        S_CHECK    = 3'd3,
        S_PROGRAM  = 3'd4,
        S_FINISH   = 3'd5
    } state_t;

    typedef struct packed {
        logic             hit;
        logic [COL_W-1:0] col;
    } guard_t;

    // Page-0 row to guard-column map.
    function automatic guard_t row_guard(input logic [ROW_W-1:0] row);
        guard_t g;
        g.hit = 1'b1;
        g.col = '0;
        if (row == 8'd4)                 g.col = 5'd31;
        else if (row == 8'd37)           g.col = 5'd28;
        else if (row inside {[8:11]})    g.col = 5'd27;
        else if (row inside {[12:19]})   g.col = 5'd11;
        else if (row inside {[20:27]})   g.col = 5'd13;
        else if (row inside {[28:35]})   g.col = 5'd15;
        else if (row inside {[64:71]})   g.col = 5'd6;
        else if (row inside {[72:79]})   g.col = 5'd7;
        else if (row inside {[80:87]})   g.col = 5'd8;
        else                             g.hit = 1'b0;
        return g;
    endfunction

endpackage

// File: rtl/fpg_sticky.sv
module fpg_sticky (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    output logic        q
);
    logic unused_hi;
    assign unused_hi = ^wdata[31:1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= 1'b0;
        else if (wr)
            q <= q | wdata[0];
    end
endmodule

// File: rtl/fpg_classify.sv
module fpg_classify
    import fpg_pkg::*;
#(
    parameter int GUARD_PAGE  = 0,
    parameter int ZONE_PAGE   = 2,
    parameter int ZONE_FIRST  = 129 * 32,
    parameter int ZONE_LAST   = 255 * 32 + 27,
    parameter int ZONE_COL    = 16,
    parameter int STICKY_LO   = 44,
    parameter int STICKY_HI   = 51
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              prog_en,
    input  logic              sticky,
    output verdict_t          verdict,
    output logic [COL_W-1:0]  guard_col
);
    localparam logic [PAGE_W-1:0] PG_G  = PAGE_W'(GUARD_PAGE);
    localparam logic [PAGE_W-1:0] PG_Z  = PAGE_W'(ZONE_PAGE);
    localparam logic [OFS_W-1:0]  Z_LO  = OFS_W'(ZONE_FIRST);
    localparam logic [OFS_W-1:0]  Z_HI  = OFS_W'(ZONE_LAST);
    localparam logic [ROW_W-1:0]  S_LO  = ROW_W'(STICKY_LO);
    localparam logic [ROW_W-1:0]  S_HI  = ROW_W'(STICKY_HI);

    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  row;
    logic [OFS_W-1:0]  ofs;
    guard_t            g;

    assign page = addr[ADDR_W-1 -: PAGE_W];
    assign row  = addr[COL_W +: ROW_W];
    assign ofs  = addr[OFS_W-1:0];
    assign g    = row_guard(row);

    always_comb begin
        verdict   = V_ALLOW;
        guard_col = '0;
        if (!prog_en) begin
            verdict = V_DENY;
        end else if (page == PG_G) begin
            if (sticky && row >= S_LO && row <= S_HI) begin
                verdict = V_DENY;
            end else if (g.hit) begin
                verdict   = V_LOOKUP;
                guard_col = g.col;
            end
        end else if (page == PG_Z) begin
            if (ofs >= Z_LO && ofs <= Z_HI) begin
                verdict   = V_LOOKUP;
                guard_col = COL_W'(ZONE_COL);
            end
        end
    end
endmodule

// File: rtl/fpg_flags.sv
module fpg_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       post,
    input  logic       post_err,
    input  logic [1:0] clr,
    output logic       done,
    output logic       err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else begin
            done <= post | (done & ~clr[0]);
            err  <= (post & post_err) | (err & ~clr[1]);
        end
    end
endmodule

// File: rtl/fuse_prog_guard.sv
module fuse_prog_guard
    import fpg_pkg::*;
#(
    parameter int GUARD_ROW = 43,
    parameter int ZONE_PAGE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_prog_en,
    input  logic              lock_wr,
    input  logic [31:0]       lock_wdata,
    output logic              lock_q,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              lk_req,
    output logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_bit,
    output logic              set_valid,
    output logic [ADDR_W-1:0] set_addr,
    input  logic              set_fail,
    input  logic [1:0]        flag_clr,
    output logic              done_flag,
    output logic              err_flag
);
    localparam logic [ROW_W-1:0] G_ROW = ROW_W'(GUARD_ROW);

    state_t            state, state_n;
    verdict_t          verdict;
    logic [COL_W-1:0]  guard_col;
    logic [ADDR_W-1:0] addr_q;
    logic [COL_W-1:0]  col_q;
    logic              err_q;
    logic              finishing;

    fpg_sticky u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (lock_wr),
        .wdata (lock_wdata),
        .q     (lock_q)
    );

    fpg_classify #(.ZONE_PAGE(ZONE_PAGE)) u_classify (
        .addr      (addr_q),
        .prog_en   (cfg_prog_en),
        .sticky    (lock_q),
        .verdict   (verdict),
        .guard_col (guard_col)
    );

    fpg_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .post     (finishing),
        .post_err (err_q),
        .clr      (flag_clr),
        .done     (done_flag),
        .err      (err_flag)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_n;
    end

    // Transitions
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:     if (req_valid) state_n = S_CLASSIFY;
            S_CLASSIFY: begin
                unique case (verdict)
                    V_DENY:   state_n = S_FINISH;
                    V_LOOKUP: state_n = S_LOOKUP;
                    default:  state_n = S_PROGRAM;
                endcase
            end
            S_LOOKUP:   state_n = S_CHECK;
            S_CHECK:    state_n = lk_bit ? S_FINISH : S_PROGRAM;
            S_PROGRAM:  state_n = S_FINISH;
            S_FINISH:   state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy      = (state != S_IDLE);
        lk_req    = (state == S_LOOKUP);
        set_valid = (state == S_PROGRAM);
        finishing = (state == S_FINISH);
        lk_addr   = {PAGE_W'(0), G_ROW, col_q};
        set_addr  = addr_q;
    end

    // Request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            col_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    addr_q <= req_addr;
                    err_q  <= 1'b0;
                end
                S_CLASSIFY: begin
                    col_q <= guard_col;
                    if (verdict == V_DENY) err_q <= 1'b1;
                end
                S_CHECK:   if (lk_bit) err_q <= 1'b1;
                S_PROGRAM: if (set_fail) err_q <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fuse_prog_guard_chk.sv
module fuse_prog_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        lk_req,
    input logic [16:0] lk_addr,
    input logic        lk_bit,
    input logic        set_valid,
    input logic        lock_q,
    input logic [1:0]  flag_clr,
    input logic        done_flag,
    input logic        err_flag
);
    assert_lookup_row_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> lk_addr[16:5] == {4'd0, 8'd43});

    assert_guard_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && $past(lk_req, 2)) |-> !$past(lk_bit));

    assert_set_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |=> !set_valid);

    assert_set_in_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> busy);

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_valid, lk_req}));

    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !flag_clr[1]) |=> err_flag);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> ($past(busy) && !busy));
endmodule

bind fuse_prog_guard fuse_prog_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .lk_req    (lk_req),
    .lk_addr   (lk_addr),
    .lk_bit    (lk_bit),
    .set_valid (set_valid),
    .lock_q    (lock_q),
    .flag_clr  (flag_clr),
    .done_flag (done_flag),
    .err_flag  (err_flag)
);

// File: tb/fuse_prog_guard_test.sv
`timescale 1ns/1ps
module fuse_prog_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_prog_en = 1'b1;
    logic        lock_wr = 1'b0;
    logic [31:0] lock_wdata = '0;
    logic        lock_q;
    logic        req_valid = 1'b0;
    logic [16:0] req_addr = '0;
    logic        busy, lk_req, set_valid, done_flag, err_flag, lk_bit, set_fail;
    logic [16:0] lk_addr, set_addr;
    logic [1:0]  flag_clr = '0;

    logic [31:0] fuse_word = '0;
    logic        fail_on = 1'b0;
    logic [4:0]  lk_hold = '0;

    int checks = 0, errors = 0;
    bit done_run = 0;
    int n_set = 0, n_lk = 0;
    logic [16:0] last_set = '0;
    logic [4:0]  last_col = '0;
    bit model_done = 0, model_err = 0;

    always #10 clk = ~clk;

    fuse_prog_guard uut (
        .clk(clk), .rst_n(rst_n), .cfg_prog_en(cfg_prog_en),
        .lock_wr(lock_wr), .lock_wdata(lock_wdata), .lock_q(lock_q),
        .req_valid(req_valid), .req_addr(req_addr), .busy(busy),
        .lk_req(lk_req), .lk_addr(lk_addr), .lk_bit(lk_bit),
        .set_valid(set_valid), .set_addr(set_addr), .set_fail(set_fail),
        .flag_clr(flag_clr), .done_flag(done_flag), .err_flag(err_flag)
    );

    // Fuse array stand-in: guard value one cycle after the lookup.
    always @(posedge clk) if (lk_req) lk_hold <= lk_addr[4:0];
    assign lk_bit   = fuse_word[lk_hold];
    assign set_fail = fail_on;

    always @(negedge clk) begin
        if (set_valid) begin n_set = n_set + 1; last_set = set_addr; end
        if (lk_req) begin
            n_lk = n_lk + 1;
            last_col = lk_addr[4:0];
            if (lk_addr[16:5] != {4'd0, 8'd43}) begin
                errors = errors + 1;
                $display("FAIL R1: lookup row field %h expected %h", lk_addr[16:5], {4'd0, 8'd43});
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Guard column for an address, -1 when none.
    function automatic int exp_guard(int p, int r, int c);
        if (p == 0) begin
            if (r == 4) return 31;
            if (r == 37) return 28;
            if (r >= 8 && r <= 11) return 27;
            if (r >= 12 && r <= 19) return 11;
            if (r >= 20 && r <= 27) return 13;
            if (r >= 28 && r <= 35) return 15;
            if (r >= 64 && r <= 71) return 6;
            if (r >= 72 && r <= 79) return 7;
            if (r >= 80 && r <= 87) return 8;
            return -1;
        end
        if (p == 2 && (r * 32 + c) >= 129 * 32 && (r * 32 + c) <= 255 * 32 + 27) return 16;
        return -1;
    endfunction

    task automatic run_req(input logic [16:0] a, input bit clr, input string tag);
        int p = int'(a[16:13]);
        int r = int'(a[12:5]);
        int c = int'(a[4:0]);
        int g = exp_guard(p, r, c);
        bit pre = !cfg_prog_en || (lock_q && p == 0 && r >= 44 && r <= 51);
        int lat; int es; int el; bit eerr; bit early;
        logic [31:0] act, exp;
        if (pre) begin lat = 2; es = 0; el = 0; eerr = 1; end
        else if (g < 0) begin lat = 3; es = 1; el = 0; eerr = fail_on; end
        else if (fuse_word[g]) begin lat = 4; es = 0; el = 1; eerr = 1; end
        else begin lat = 5; es = 1; el = 1; eerr = fail_on; end
        if (clr) begin
            flag_clr = 2'b11;
            @(negedge clk);
            flag_clr = 2'b00;
            model_done = 0; model_err = 0;
        end
        n_set = 0; n_lk = 0; last_set = '0; last_col = '0;
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (lat - 1) @(negedge clk);
        early = done_flag;
        @(negedge clk);
        act = {early, done_flag, err_flag, busy, 2'(n_set), 2'(n_lk),
               (n_lk > 0) ? last_col : 5'd0, (n_set > 0) ? last_set : 17'd0};
        exp = {model_done, 1'b1, model_err | eerr, 1'b0, 2'(es), 2'(el),
               (el > 0) ? 5'(g) : 5'd0, (es > 0) ? a : 17'd0};
        check(act == exp, {tag, " R7 R9"}, act, exp);
        model_done = 1; model_err = model_err | eerr;
    endtask

    task automatic wr_lock(input logic [31:0] d, input logic exp, input string tag);
        lock_wr = 1'b1; lock_wdata = d;
        @(negedge clk);
        lock_wr = 1'b0;
        check(lock_q == exp, tag, 32'(lock_q), 32'(exp));
    endtask

    task automatic sweep_pages(input int pmax, input bit only02, input string tag);
        for (int p = 0; p <= pmax; p++) begin
            if (!only02 || p == 0 || p == 2)
                for (int r = 0; r < 256; r++)
                    run_req({4'(p), 8'(r), 5'((r * 7 + p) % 32)}, 1'b1, tag);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int guards [10] = '{31, 28, 27, 11, 13, 15, 6, 7, 8, 16};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({done_flag, err_flag, busy, lock_q, set_valid, lk_req} == 6'b0, "reset R7",
              32'({done_flag, err_flag, busy, lock_q, set_valid, lk_req}), 32'd0);

        // All pages, no guards blown: everything permitted.
        sweep_pages(15, 1'b0, "R1 R4 R5");

        // Each guard fuse alone on pages 0 and 2.
        foreach (guards[i]) begin
            fuse_word = 32'd1 << guards[i];
            sweep_pages(2, 1'b1, "R4 R5 R11");
        end

        // Page-2 zone edges.
        fuse_word = 32'd1 << 16;
        run_req({4'd2, 8'd128, 5'd31}, 1'b1, "R5 edge below");
        run_req({4'd2, 8'd129, 5'd0},  1'b1, "R5 edge first");
        run_req({4'd2, 8'd255, 5'd27}, 1'b1, "R5 edge last");
        run_req({4'd2, 8'd255, 5'd28}, 1'b1, "R5 edge above");

        // Sticky lock behaviour and its denial band.
        fuse_word = '0;
        wr_lock(32'hFFFF_FFFE, 1'b0, "R6 high bits ignored");
        run_req({4'd0, 8'd44, 5'd3}, 1'b1, "R3 unlocked");
        wr_lock(32'h0000_0003, 1'b1, "R6 set");
        wr_lock(32'h0000_0000, 1'b1, "R6 zero keeps");
        fuse_word = 32'hFFFF_FFFF;
        sweep_pages(2, 1'b1, "R3 R4 R5");

        // Program enable off.
        cfg_prog_en = 1'b0;
        fuse_word = '0;
        sweep_pages(5, 1'b0, "R2");
        cfg_prog_en = 1'b1;

        // Array failure and sticky error.
        fail_on = 1'b1;
        run_req({4'd5, 8'd9, 5'd1}, 1'b1, "R7 set_fail");
        fail_on = 1'b0;
        run_req({4'd5, 8'd9, 5'd2}, 1'b0, "R8 error kept");
        run_req({4'd0, 8'd4, 5'd0}, 1'b0, "R8 after lookup");

        // Write-1-to-clear per bit.
        flag_clr = 2'b01;
        @(negedge clk);
        flag_clr = 2'b00;
        check({done_flag, err_flag} == 2'b01, "R7 clear done only", 32'({done_flag, err_flag}), 32'd1);
        flag_clr = 2'b10;
        @(negedge clk);
        flag_clr = 2'b00;
        check({done_flag, err_flag} == 2'b00, "R7 clear error", 32'({done_flag, err_flag}), 32'd0);

        // Request while busy is ignored.
        n_set = 0; last_set = '0;
        req_valid = 1'b1; req_addr = {4'd5, 8'd3, 5'd1};
        @(negedge clk);
        req_addr = {4'd6, 8'd7, 5'd7};
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        check(done_flag && !busy && n_set == 1 && last_set == {4'd5, 8'd3, 5'd1}, "R10 busy ignore",
              {12'(n_set), 3'd0, last_set}, {12'd1, 3'd0, 4'd5, 8'd3, 5'd1});
        repeat (4) @(negedge clk);
        check(n_set == 1 && !busy, "R10 no late start", 32'(n_set), 32'd1);

        // Reset clears the sticky lock.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({lock_q, done_flag, err_flag} == 3'b0, "R6 reset", 32'({lock_q, done_flag, err_flag}), 32'd0);

        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule